// File: doc/BRIEF.md
# Serial Packet Deframer

This block takes a one-bit-per-beat serial stream from the matching link transmitter and turns it back into a frame. While idle it hunts for a 32-bit alignment pattern; once that pattern has been seen it groups the following bits into bytes. It then walks a two-packet frame. The first packet is a header that carries the destination address and the payload length. The second packet carries the payload bytes. Each packet opens with a self-checking identifier byte and closes with a CRC-8 byte.

Payload bytes leave through a simple RAM write port, starting at RAM address zero for every frame. At the end of each frame the block pulses a done strobe. It also updates a good/bad verdict and two error flags, so the surrounding logic can decide whether the RAM contents can be used. The received address and length stay visible on the outputs.

Top module: `pkt_deframer`

## Requirements
- R1: Frame reception starts only after the bits 0xAAAA5555 have arrived MSB first. Bits are sampled on a rising clock edge while bit_vld_i is high. Bits presented while bit_vld_i is low are ignored.
- R2: After alignment the bytes arrive MSB first in this fixed order: header identifier, address (4 bytes, most significant first), length (2 bytes, most significant first), header CRC, payload identifier, `length` payload bytes, payload CRC.
- R3: The high nibble of an identifier byte is its type: 0x5 for the header, 0x3 for the payload. The low nibble must be the bitwise complement of the type, so the only accepted bytes are 0x5A and 0x3C. Any other byte drops the frame: frame_done_o pulses with pid_err_o=1 and frame_ok_o=0, no payload byte is written, and the hunt for alignment resumes.
- R4: Both CRCs use CRC-8 with polynomial 0x07, initial value 0x00, MSB first and no final inversion. The header CRC covers the six address and length bytes. The payload CRC covers the payload bytes only.
- R5: A mismatch in either CRC gives crc_err_o=1 and frame_ok_o=0 at the end of the frame. The payload is still written in full.
- R6: Each frame that is completed or dropped produces exactly one single-cycle frame_done_o pulse. frame_ok_o, pid_err_o and crc_err_o change only with that pulse and hold until the next one. frame_ok_o=1 only when both identifiers and both CRCs matched.
- R7: addr_o and len_o hold the address and length of the most recent accepted header. A header whose identifier is rejected leaves them unchanged.
- R8: Each payload byte causes one wr_en_o cycle. The write addresses run 0, 1, … length-1 in arrival order, and wr_data_o carries the byte.
- R9: A frame with length zero writes nothing. It completes after the payload identifier and a payload CRC of 0x00.
- R10: No search for the alignment pattern takes place inside a frame. A payload that contains the pattern is received as ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | bit_i holds a valid bit this cycle |
| wr_en_o | output | 1 | RAM write strobe for one payload byte |
| wr_addr_o | output | RAM_AW | RAM write address |
| wr_data_o | output | 8 | RAM write data |
| frame_done_o | output | 1 | One-cycle end-of-frame strobe |
| frame_ok_o | output | 1 | Last frame was received without error |
| pid_err_o | output | 1 | Last frame was dropped on a bad identifier |
| crc_err_o | output | 1 | Last frame had a CRC mismatch |
| addr_o | output | ADDR_W | Received address |
| len_o | output | LEN_W | Received payload length |

## Verification
The assertions rely on a few limits on the input stream. A received length must never exceed the RAM depth. After a frame ends, the next alignment pattern must start no sooner than two cycles later, because bits that arrive while the deframer returns to hunting are discarded. The stimulus follows both limits: payloads stay at 40 bytes or fewer, and each frame is followed by several idle cycles with bit_vld_i low. Inside a frame the stimulus leaves random cycles with bit_vld_i low that carry random data.

// File: rtl/deframer_pkg.sv
package deframer_pkg;
  localparam int unsigned SYNC_W = 32;
  localparam logic [SYNC_W-1:0] SYNC_WORD = 32'hAAAA5555;
  localparam logic [3:0] SOF_TYPE = 4'h5;
  localparam logic [3:0] DAT_TYPE = 4'h3;
  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef enum logic [2:0] {
    ST_HUNT, ST_SOF_PID, ST_ADDR, ST_LEN, ST_SOF_CRC, ST_DAT_PID, ST_PAYLOAD, ST_DAT_CRC
  } dfr_state_e;

  function automatic logic [7:0] crc8_byte(input logic [7:0] crc, input logic [7:0] data);
    logic [7:0] c;
    c = crc ^ data;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/dfr_sync_hunt.sv
module dfr_sync_hunt #(
  parameter int unsigned SYNC_W = 32,
  parameter logic [SYNC_W-1:0] SYNC_VAL = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_vld_i,
  input  logic hunt_i,
  output logic hit_o
);
  logic [SYNC_W-1:0] shreg_q;
  logic [SYNC_W-1:0] window;

  assign window = {shreg_q[SYNC_W-2:0], bit_i};
  assign hit_o  = hunt_i && bit_vld_i && (window == SYNC_VAL);

  // history is flushed while a frame is open so frame bits never feed a later match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          shreg_q <= '0;
    else if (!hunt_i)     shreg_q <= '0;
    else if (bit_vld_i)   shreg_q <= window;
  end
endmodule

// File: rtl/dfr_byte_deser.sv
module dfr_byte_deser (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_vld_i,
  input  logic       clr_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o
);
  logic [2:0] cnt_q;
  logic [6:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sr_q       <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q      <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (bit_vld_i) begin
        sr_q  <= {sr_q[5:0], bit_i};
        cnt_q <= cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          byte_o     <= {sr_q, bit_i};
          byte_vld_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dfr_crc8_acc.sv
module dfr_crc8_acc (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  import deframer_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_o <= '0;
    else if (clr_i)   crc_o <= '0;
    else if (en_i)    crc_o <= crc8_byte(crc_o, data_i);
  end
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
  import deframer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned RAM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  output logic              wr_en_o,
  output logic [RAM_AW-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              frame_done_o,
  output logic              frame_ok_o,
  output logic              pid_err_o,
  output logic              crc_err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [LEN_W-1:0] ADDR_LAST = LEN_W'(ADDR_W / 8 - 1);
  localparam logic [LEN_W-1:0] LEN_LAST  = LEN_W'(LEN_W / 8 - 1);
  localparam logic [7:0] SOF_PID = {SOF_TYPE, ~SOF_TYPE};
  localparam logic [7:0] DAT_PID = {DAT_TYPE, ~DAT_TYPE};

  dfr_state_e       state_q;
  logic             hunting, sync_hit;
  logic [7:0]       rx_byte, crc_val;
  logic             rx_vld, crc_clr, crc_en;
  logic [LEN_W-1:0] cnt_q;
  logic             sof_bad_q;
  logic             dat_bad;

  assign hunting = (state_q == ST_HUNT);

  dfr_sync_hunt #(.SYNC_W(SYNC_W), .SYNC_VAL(SYNC_WORD)) u_hunt (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .hunt_i(hunting), .hit_o(sync_hit)
  );

  dfr_byte_deser u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .clr_i(hunting), .byte_o(rx_byte), .byte_vld_o(rx_vld)
  );

  assign crc_clr = rx_vld && (state_q == ST_SOF_PID || state_q == ST_DAT_PID);
  assign crc_en  = rx_vld && (state_q == ST_ADDR || state_q == ST_LEN || state_q == ST_PAYLOAD);
  assign dat_bad = (rx_byte != crc_val);

  dfr_crc8_acc u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(crc_clr), .en_i(crc_en),
    .data_i(rx_byte), .crc_o(crc_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_HUNT;
      cnt_q        <= '0;
      sof_bad_q    <= 1'b0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      frame_done_o <= 1'b0;
      frame_ok_o   <= 1'b0;
      pid_err_o    <= 1'b0;
      crc_err_o    <= 1'b0;
      addr_o       <= '0;
      len_o        <= '0;
    end else begin
      frame_done_o <= 1'b0;
      wr_en_o      <= 1'b0;
      if (hunting) begin
        if (sync_hit) begin
          state_q   <= ST_SOF_PID;
          sof_bad_q <= 1'b0;
        end
      end else if (rx_vld) begin
        unique case (state_q)
          ST_SOF_PID, ST_DAT_PID: begin
            if (rx_byte == ((state_q == ST_SOF_PID) ? SOF_PID : DAT_PID)) begin
              cnt_q <= '0;
              if (state_q == ST_SOF_PID)  state_q <= ST_ADDR;
              else if (len_o == '0)       state_q <= ST_DAT_CRC;
              else                        state_q <= ST_PAYLOAD;
            end else begin
              frame_done_o <= 1'b1;
              frame_ok_o   <= 1'b0;
              pid_err_o    <= 1'b1;
              crc_err_o    <= 1'b0;
              state_q      <= ST_HUNT;
            end
          end
          ST_ADDR: begin
            addr_o <= {addr_o[ADDR_W-9:0], rx_byte};
            if (cnt_q == ADDR_LAST) begin
              cnt_q   <= '0;
              state_q <= ST_LEN;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_LEN: begin
            len_o <= {len_o[LEN_W-9:0], rx_byte};
            if (cnt_q == LEN_LAST) state_q <= ST_SOF_CRC;
            else                   cnt_q <= cnt_q + 1'b1;
          end
          ST_SOF_CRC: begin
            sof_bad_q <= dat_bad;
            state_q   <= ST_DAT_PID;
          end
          ST_PAYLOAD: begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= cnt_q[RAM_AW-1:0];
            wr_data_o <= rx_byte;
            if (cnt_q == len_o - 1'b1) state_q <= ST_DAT_CRC;
            else                       cnt_q <= cnt_q + 1'b1;
          end
          ST_DAT_CRC: begin
            frame_done_o <= 1'b1;
            frame_ok_o   <= !sof_bad_q && !dat_bad;
            crc_err_o    <= sof_bad_q || dat_bad;
            pid_err_o    <= 1'b0;
            state_q      <= ST_HUNT;
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_deframer_chk.sv
module pkt_deframer_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned RAM_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_o,
  input logic [RAM_AW-1:0] wr_addr_o,
  input logic              frame_done_o,
  input logic              frame_ok_o,
  input logic              pid_err_o,
  input logic              crc_err_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [LEN_W-1:0]  len_o
);
  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (LEN_W'(wr_addr_o) < len_o)); // R8
  AST_WR_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o); // R6
  AST_OK_ONLY_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_ok_o) |-> frame_done_o); // R6
  AST_OK_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |-> (!crc_err_o && !pid_err_o)); // R5
  AST_PID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pid_err_o |-> (!frame_ok_o && !crc_err_o)); // R3
  AST_NO_WR_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_o == '0) |-> !wr_en_o); // R9
  AST_ADDR_HOLD_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> $stable(addr_o)); // R7
endmodule

bind pkt_deframer pkt_deframer_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RAM_AW(RAM_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
  .frame_done_o(frame_done_o), .frame_ok_o(frame_ok_o), .pid_err_o(pid_err_o),
  .crc_err_o(crc_err_o), .addr_o(addr_o), .len_o(len_o)
);

// File: tb/pkt_deframer_tb.sv
module pkt_deframer_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_i = 1'b0;
  logic        bit_vld_i = 1'b0;
  logic        wr_en_o;
  logic [7:0]  wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        frame_done_o, frame_ok_o, pid_err_o, crc_err_o;
  logic [31:0] addr_o;
  logic [15:0] len_o;

  int n_cmp = 0, n_bad = 0;
  int wr_cnt, wr_bad, done_cnt;
  logic [7:0]  pl [0:63];
  logic [31:0] exp_addr = '0;
  logic [15:0] exp_len = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pkt_deframer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .frame_done_o(frame_done_o), .frame_ok_o(frame_ok_o), .pid_err_o(pid_err_o),
    .crc_err_o(crc_err_o), .addr_o(addr_o), .len_o(len_o)
  );

  always @(negedge clk_i) if (rst_ni) begin
    if (wr_en_o) begin
      if (wr_addr_o != 8'(wr_cnt) || wr_data_o != pl[wr_cnt[5:0]]) wr_bad++;
      wr_cnt++;
    end
    if (frame_done_o) done_cnt++;
  end

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    if ($urandom_range(3) == 0) begin
      bit_vld_i = 1'b0; bit_i = 1'($urandom); // R1: ignored bit
      @(negedge clk_i);
    end
    bit_i = b; bit_vld_i = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); bit_vld_i = 1'b0; bit_i = 1'($urandom);
    end
  endtask

  // mode: 0 good, 1 bad header id, 2 bad payload id, 3 bad header crc, 4 bad payload crc, 5 sync in payload
  task automatic run_frame(input logic [31:0] a, input int len, input int mode);
    logic [7:0] c;
    logic [7:0] hp, dp;
    int junk;
    wr_cnt = 0; wr_bad = 0; done_cnt = 0;
    for (int i = 0; i < len; i++) pl[i] = 8'($urandom);
    if (mode == 5 && len >= 6) begin
      pl[1] = 8'hAA; pl[2] = 8'hAA; pl[3] = 8'h55; pl[4] = 8'h55;
    end
    hp = (mode == 1) ? 8'h5B : 8'h5A;
    dp = (mode == 2) ? 8'h33 : 8'h3C;
    junk = $urandom_range(16);
    for (int i = 0; i < junk; i++) send_bit(1'($urandom));
    send_byte(8'hAA); send_byte(8'hAA); send_byte(8'h55); send_byte(8'h55);
    send_byte(hp);
    c = 8'h00;
    for (int i = 3; i >= 0; i--) begin send_byte(a[i*8 +: 8]); c = ref_crc(c, a[i*8 +: 8]); end
    send_byte(8'(len >> 8)); c = ref_crc(c, 8'(len >> 8));
    send_byte(8'(len));      c = ref_crc(c, 8'(len));
    send_byte(mode == 3 ? ~c : c);
    send_byte(dp);
    c = 8'h00;
    for (int i = 0; i < len; i++) begin send_byte(pl[i]); c = ref_crc(c, pl[i]); end
    send_byte(mode == 4 ? c ^ 8'h10 : c);
    idle(6);
    if (mode != 1) begin exp_addr = a; exp_len = 16'(len); end
    chk("R6 one done pulse", 64'(done_cnt), 64'd1);
    chk("R3 pid_err", 64'(pid_err_o), 64'(mode == 1 || mode == 2));
    chk("R4/R5 crc_err", 64'(crc_err_o), 64'(mode == 3 || mode == 4));
    chk("R6 frame_ok", 64'(frame_ok_o), 64'(mode == 0 || mode == 5));
    chk("R7 addr_o", 64'(addr_o), 64'(exp_addr));
    chk("R7 len_o", 64'(len_o), 64'(exp_len));
    chk("R8 write count", 64'(wr_cnt), 64'((mode == 1 || mode == 2) ? 0 : len));
    chk("R8 write addr/data", 64'(wr_bad), 64'd0);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk_i);
    chk("R6 reset done", 64'(frame_done_o), 0);
    chk("R6 reset ok", 64'(frame_ok_o), 0);
    chk("R3 reset pid_err", 64'(pid_err_o), 0);
    chk("R8 reset wr_en", 64'(wr_en_o), 0);
    rst_ni = 1'b1;
    idle(3);
    run_frame(32'h12345678, 5, 0);        // R2 basic
    run_frame(32'hCAFE0001, 0, 0);        // R9 empty payload
    run_frame(32'h0BAD0BAD, 8, 1);        // R3 bad header id, R7 hold
    run_frame(32'h00FF00FF, 7, 2);        // R3 bad payload id
    run_frame(32'h13579BDF, 9, 3);        // R5 header crc
    run_frame(32'h2468ACE0, 12, 4);       // R5 payload crc
    run_frame(32'hA5A5A5A5, 10, 5);       // R10 sync inside payload
    run_frame(32'hFFFFFFFF, 1, 0);        // R8 single byte
    run_frame(32'h00000000, 0, 4);        // R9 empty payload, bad crc
    for (int k = 0; k < 20; k++)          // R1 R4 random traffic
      run_frame($urandom, $urandom_range(40), ($urandom_range(4) == 0) ? $urandom_range(1, 5) : 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule